// File: doc/BRIEF.md
# Real-Time Clock Register Block with Periodic Interrupt

This block is a small wall-clock timekeeper that software reaches through two byte-wide ports. A write to the index port selects one internal register. A following read or write on the data port then touches that register. A slow tick enable, nominally 32.768 kHz, drives a prescaler. The prescaler produces one-second rollovers of a seconds/minutes/hours counter and a programmable periodic event.

Time is held in binary inside the block. Each read and write of a time register passes through the format that the control register selects: BCD or binary, and 12-hour or 24-hour. An update-in-progress bit warns software that a rollover is about to happen, so that it can avoid reading a half-updated time.

Two sources feed a sticky status register: the periodic event and the end of each seconds update. Each source has its own enable, and together they drive one active-high interrupt line. The line stays high until software reads the status register. That read clears the flags.

Top module: `rtc_cmos_core`

## Requirements
- R1: Bits 6:0 of a value written to the index port choose the register and bit 7 is discarded. Seconds sit at 0x00, minutes at 0x02, hours at 0x04, rate/control A at 0x0A, control B at 0x0B and status C at 0x0C. Any other index reads 0x00.
- R2: After reset, A reads 0x26, B reads 0x02, C reads 0x00, every time register reads zero and `irq` is low.
- R3: While `tick_en` is high on every cycle, seconds advance once per 2^DIV_BITS ticks. Seconds carry from 59 to 0 into minutes, minutes carry from 59 to 0 into hours, and hours wrap from 23 to 0. Time does not move while `tick_en` is low.
- R4: A bit 7 (update in progress) is high during the last UIP_TICKS ticks of each second. Time registers change only on a cycle that follows a cycle with that bit high, or when software writes them.
- R5: B bit 2 = 1 selects binary and B bit 2 = 0 selects BCD for every read and write of seconds, minutes and hours.
- R6: B bit 1 = 1 selects 24-hour hours. With B bit 1 = 0, hours show 1 to 12 and bit 7 is set for PM. In BCD, hour 0 reads 0x12, hour 12 reads 0x92 and hour 16 reads 0x84.
- R7: A rate field A[3:0] = r with r nonzero raises the periodic flag once every 2^(r-1) ticks. r = 1 and r = 2 act as 8 and 9. r = 0 never raises it.
- R8: Each seconds rollover sets the update-ended flag.
- R9: C reads {IRQF, PF, AF, UF, 4'b0000} from bit 7 down. AF is always 0. Writes to C have no effect.
- R10: IRQF, which drives `irq`, is set whenever PF is set with B bit 6 = 1 or UF is set with B bit 4 = 1. It stays set until C is read.
- R11: A read of C clears PF, UF and IRQF at the next edge, so `irq` falls on the following cycle. An event in the same cycle as that read is kept and shows in the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable per 32.768 kHz tick |
| idx_we | input | 1 | Write strobe for the index port |
| data_we | input | 1 | Write strobe for the data port |
| data_re | input | 1 | Read strobe for the data port (clears C when C is selected) |
| wdata | input | 8 | Write data for either port |
| rdata | output | 8 | Contents of the selected register, formatted |
| irq | output | 1 | Active-high interrupt request |

## Verification
Two functions can land on the same clock edge: a status read that clears the flags, and a new periodic event that sets PF. The bench first measures the periodic interval. It then issues a read of C timed so that the clearing edge is exactly the next event edge. The result passes if the read itself returns no PF, `irq` is still high afterwards, and a second read shows both IRQF and PF. Together these show that the event was neither lost nor cleared.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam logic [6:0] IDX_SEC  = 7'h00;
   localparam logic [6:0] IDX_MIN  = 7'h02;
   localparam logic [6:0] IDX_HOUR = 7'h04;
   localparam logic [6:0] IDX_CTLA = 7'h0A;
   localparam logic [6:0] IDX_CTLB = 7'h0B;
   localparam logic [6:0] IDX_STAT = 7'h0C;

   localparam logic [6:0] CTLA_RESET = 7'h26;
   localparam logic [7:0] CTLB_RESET = 8'h02;

   localparam int B_PIE = 6;
   localparam int B_UIE = 4;
   localparam int B_BIN = 2;
   localparam int B_H24 = 1;

   typedef enum logic [1:0] {TSEL_SEC, TSEL_MIN, TSEL_HOUR} tsel_e;

   typedef struct packed {
      logic [5:0] sec;
      logic [5:0] min;
      logic [4:0] hour;
   } rtc_time_t;

   function automatic logic [7:0] to_bcd(input logic [6:0] v);
      return {4'(v / 7'd10), 4'(v % 7'd10)};
   endfunction

   function automatic logic [6:0] from_bcd(input logic [7:0] d);
      return 7'(d[7:4]) * 7'd10 + 7'(d[3:0]);
   endfunction

   function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
      return bin ? {1'b0, v} : to_bcd(v);
   endfunction

   function automatic logic [6:0] dec_val(input logic [7:0] d, input logic bin);
      return bin ? d[6:0] : from_bcd(d);
   endfunction

   function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin,
                                           input logic h24);
      logic [4:0] h12;
      logic [7:0] r;
      if (h24) return enc_val({2'b00, h}, bin);
      if (h == 5'd0)       h12 = 5'd12;
      else if (h > 5'd12)  h12 = h - 5'd12;
      else                 h12 = h;
      r    = enc_val({2'b00, h12}, bin);
      r[7] = (h >= 5'd12);
      return r;
   endfunction

   function automatic logic [4:0] dec_hour(input logic [7:0] d, input logic bin,
                                           input logic h24);
      logic [6:0] v;
      if (h24) return 5'(dec_val(d, bin));
      v = dec_val({1'b0, d[6:0]}, bin);
      if (v == 7'd12) v = 7'd0;
      return 5'(v) + (d[7] ? 5'd12 : 5'd0);
   endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
   parameter int DIV_BITS        = 15,
   parameter int UIP_TICKS       = 8,
   parameter bit ALIAS_LOW_RATES = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic [3:0] rate,
   output logic       sec_evt,
   output logic       per_evt,
   output logic       uip
);

   localparam int                CNT_W     = 15;
   localparam int                SEC_TICKS = 1 << DIV_BITS;
   localparam logic [DIV_BITS-1:0] UIP_FIRST = DIV_BITS'(SEC_TICKS - UIP_TICKS);

   if (DIV_BITS < 4 || DIV_BITS > CNT_W) begin : g_bad_div
      $error("rtc_divider: DIV_BITS must lie in 4..15");
   end
   if (UIP_TICKS < 1 || UIP_TICKS > SEC_TICKS / 2) begin : g_bad_uip
      $error("rtc_divider: UIP_TICKS must lie in 1..half a second");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [3:0]       rate_eff;
   logic [CNT_W-1:0] per_mask;

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (tick_en) cnt_q <= cnt_q + 1'b1;
   end

   if (ALIAS_LOW_RATES) begin : g_alias
      assign rate_eff = (rate == 4'd1 || rate == 4'd2) ? rate + 4'd7 : rate;
   end else begin : g_direct
      assign rate_eff = rate;
   end

   always_comb per_mask = (CNT_W'(1) << (rate_eff - 4'd1)) - CNT_W'(1);

   assign sec_evt = tick_en && (cnt_q[DIV_BITS-1:0] == '1);
   assign per_evt = tick_en && (rate_eff != 4'd0) && ((cnt_q & per_mask) == per_mask);
   assign uip     = cnt_q[DIV_BITS-1:0] >= UIP_FIRST;

endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
   import rtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sec_evt,
   input  logic       uip,
   input  logic       wr_en,
   input  tsel_e      wr_sel,
   input  logic [6:0] wr_val,
   output rtc_time_t  tm
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tm <= '0;
      end else if (wr_en) begin
         case (wr_sel)
            TSEL_SEC:  tm.sec  <= 6'(wr_val);
            TSEL_MIN:  tm.min  <= 6'(wr_val);
            TSEL_HOUR: tm.hour <= 5'(wr_val);
            default:   tm.sec  <= tm.sec;
         endcase
      end else if (sec_evt) begin
         if (tm.sec >= 6'd59) begin
            tm.sec <= 6'd0;
            if (tm.min >= 6'd59) begin
               tm.min  <= 6'd0;
               tm.hour <= (tm.hour >= 5'd23) ? 5'd0 : tm.hour + 5'd1;
            end else begin
               tm.min <= tm.min + 6'd1;
            end
         end else begin
            tm.sec <= tm.sec + 6'd1;
         end
      end
   end

   // R4: outside the update window and without a write, time holds
   p_time_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !uip) |=> $stable(tm));

   // R3: a rollover from 59 seconds lands on 0
   p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_evt && !wr_en && tm.sec == 6'd59) |=> (tm.sec == 6'd0));

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       per_evt,
   input  logic       sec_evt,
   input  logic       pie,
   input  logic       uie,
   input  logic       rd_clr,
   output logic [7:0] stat,
   output logic       irq
);

   logic pf_q, uf_q, irqf_q;
   logic pf_d, uf_d, irqf_d;

   always_comb begin
      pf_d   = (pf_q & ~rd_clr) | per_evt;
      uf_d   = (uf_q & ~rd_clr) | sec_evt;
      irqf_d = (irqf_q & ~rd_clr) | (pf_d & pie) | (uf_d & uie);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pf_q   <= 1'b0;
         uf_q   <= 1'b0;
         irqf_q <= 1'b0;
      end else begin
         pf_q   <= pf_d;
         uf_q   <= uf_d;
         irqf_q <= irqf_d;
      end
   end

   assign stat = {irqf_q, pf_q, 1'b0, uf_q, 4'b0000};
   assign irq  = irqf_q;

   // R10: the request is held until software reads the status
   p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !rd_clr) |=> irq);

   // R11: a read with no coincident event leaves nothing pending
   p_read_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !per_evt && !sec_evt) |=> (!irq && stat[6:4] == 3'b000));

   // R11: an event coinciding with a read is not lost
   p_event_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      per_evt |=> stat[6]);

endmodule

// File: rtl/rtc_cmos_core.sv
module rtc_cmos_core
   import rtc_pkg::*;
#(
   parameter int DIV_BITS        = 15,
   parameter int UIP_TICKS       = 8,
   parameter bit ALIAS_LOW_RATES = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       idx_we,
   input  logic       data_we,
   input  logic       data_re,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       irq
);

   logic [6:0] idx_q;
   logic [6:0] ctla_q;
   logic [7:0] ctlb_q;
   logic       sec_evt, per_evt, uip;
   logic       rd_clr, time_we;
   tsel_e      wr_sel;
   logic [6:0] wr_val;
   rtc_time_t  tm;
   logic [7:0] stat;
   logic       fmt_bin, fmt_h24;

   assign fmt_bin = ctlb_q[B_BIN];
   assign fmt_h24 = ctlb_q[B_H24];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         ctla_q <= CTLA_RESET;
         ctlb_q <= CTLB_RESET;
      end else begin
         if (idx_we) idx_q <= wdata[6:0];
         if (data_we && idx_q == IDX_CTLA) ctla_q <= wdata[6:0];
         if (data_we && idx_q == IDX_CTLB) ctlb_q <= wdata;
      end
   end

   assign rd_clr  = data_re && (idx_q == IDX_STAT);
   assign time_we = data_we && (idx_q == IDX_SEC || idx_q == IDX_MIN || idx_q == IDX_HOUR);

   always_comb begin
      case (idx_q)
         IDX_MIN:  wr_sel = TSEL_MIN;
         IDX_HOUR: wr_sel = TSEL_HOUR;
         default:  wr_sel = TSEL_SEC;
      endcase
      if (idx_q == IDX_HOUR) wr_val = {2'b00, dec_hour(wdata, fmt_bin, fmt_h24)};
      else                   wr_val = dec_val(wdata, fmt_bin);
   end

   rtc_divider #(
      .DIV_BITS        (DIV_BITS),
      .UIP_TICKS       (UIP_TICKS),
      .ALIAS_LOW_RATES (ALIAS_LOW_RATES)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .rate    (ctla_q[3:0]),
      .sec_evt (sec_evt),
      .per_evt (per_evt),
      .uip     (uip)
   );

   rtc_timekeep u_time (
      .clk     (clk),
      .rst_n   (rst_n),
      .sec_evt (sec_evt),
      .uip     (uip),
      .wr_en   (time_we),
      .wr_sel  (wr_sel),
      .wr_val  (wr_val),
      .tm      (tm)
   );

   rtc_irq_flags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .per_evt (per_evt),
      .sec_evt (sec_evt),
      .pie     (ctlb_q[B_PIE]),
      .uie     (ctlb_q[B_UIE]),
      .rd_clr  (rd_clr),
      .stat    (stat),
      .irq     (irq)
   );

   always_comb begin
      case (idx_q)
         IDX_SEC:  rdata = enc_val({1'b0, tm.sec}, fmt_bin);
         IDX_MIN:  rdata = enc_val({1'b0, tm.min}, fmt_bin);
         IDX_HOUR: rdata = enc_hour(tm.hour, fmt_bin, fmt_h24);
         IDX_CTLA: rdata = {uip, ctla_q};
         IDX_CTLB: rdata = ctlb_q;
         IDX_STAT: rdata = stat;
         default:  rdata = 8'h00;
      endcase
   end

   // R7: with the rate field at zero no periodic flag can appear
   p_rate0_no_pf_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctla_q[3:0] == 4'd0 && !stat[6]) |=> !stat[6]);

   // R8: every seconds rollover leaves the update flag set
   p_uf_on_roll_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sec_evt |=> stat[4]);

endmodule

// File: tb/rtc_cmos_core_bench.sv
module rtc_cmos_core_bench;

   localparam int DIVB = 8;
   localparam int SECT = 1 << DIVB;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       idx_we = 1'b0;
   logic       data_we = 1'b0;
   logic       data_re = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   rtc_cmos_core #(.DIV_BITS(DIVB), .UIP_TICKS(8)) u_rtc_cmos_core (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .idx_we(idx_we),
      .data_we(data_we), .data_re(data_re), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   function automatic logic [7:0] m_enc(int v, bit bin);
      return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic logic [7:0] m_hour(int h, bit bin, bit h24);
      int h12;
      if (h24) return m_enc(h, bin);
      h12 = (h % 12 == 0) ? 12 : h % 12;
      return m_enc(h12, bin) | ((h >= 12) ? 8'h80 : 8'h00);
   endfunction

   task automatic check(string req, logic [7:0] got, logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic set_idx(logic [7:0] i);
      idx_we = 1'b1; wdata = i;
      @(negedge clk);
      idx_we = 1'b0;
   endtask

   task automatic wr_reg(logic [7:0] i, logic [7:0] d);
      set_idx(i);
      data_we = 1'b1; wdata = d;
      @(negedge clk);
      data_we = 1'b0;
   endtask

   task automatic rd_cur(output logic [7:0] d);
      data_re = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      data_re = 1'b0;
   endtask

   task automatic rd_reg(logic [7:0] i, output logic [7:0] d);
      set_idx(i);
      rd_cur(d);
   endtask

   task automatic wait_irq();
      while (!irq) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      int n;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: reset state
      rd_reg(8'h0A, d); check("R2 ctl A", d, 8'h26);
      rd_reg(8'h0B, d); check("R2 ctl B", d, 8'h02);
      rd_reg(8'h0C, d); check("R2 status", d, 8'h00);
      rd_reg(8'h00, d); check("R2 seconds", d, 8'h00);
      rd_reg(8'h04, d); check("R2 hours", d, 8'h00);
      check("R2 irq", {7'd0, irq}, 8'h00);

      // R1: index bit 7 discarded, unused index reads zero
      rd_reg(8'h8B, d); check("R1 index bit7", d, 8'h02);
      rd_reg(8'h05, d); check("R1 unused index", d, 8'h00);

      // R5 R6: random time written and read in random formats, ticks frozen
      for (int k = 0; k < 40; k++) begin
         int h, m, s;
         bit wb, wh, rb, rh;
         h = $urandom % 24; m = $urandom % 60; s = $urandom % 60;
         wb = 1'($urandom); wh = 1'($urandom); rb = 1'($urandom); rh = 1'($urandom);
         wr_reg(8'h0B, {5'd0, wb, wh, 1'b0});
         wr_reg(8'h00, m_enc(s, wb));
         wr_reg(8'h02, m_enc(m, wb));
         wr_reg(8'h04, m_hour(h, wb, wh));
         wr_reg(8'h0B, {5'd0, rb, rh, 1'b0});
         rd_reg(8'h00, d); check("R5 seconds format", d, m_enc(s, rb));
         rd_reg(8'h02, d); check("R5 minutes format", d, m_enc(m, rb));
         rd_reg(8'h04, d); check("R6 hours format", d, m_hour(h, rb, rh));
      end

      // R6: directed 12-hour BCD corners
      wr_reg(8'h0B, 8'h02);
      wr_reg(8'h04, 8'h16);
      wr_reg(8'h0B, 8'h00);
      rd_reg(8'h04, d); check("R6 16h as 4 PM", d, 8'h84);
      wr_reg(8'h04, 8'h12);
      wr_reg(8'h0B, 8'h02);
      rd_reg(8'h04, d); check("R6 12 AM is hour 0", d, 8'h00);
      wr_reg(8'h04, 8'h12);
      wr_reg(8'h0B, 8'h00);
      rd_reg(8'h04, d); check("R6 noon", d, 8'h92);

      // R3: no movement without ticks
      wr_reg(8'h0B, 8'h06);
      wr_reg(8'h00, 8'd17);
      repeat (600) @(negedge clk);
      rd_reg(8'h00, d); check("R3 frozen without tick", d, 8'd17);

      // R9: writes to status ignored
      rd_reg(8'h0C, d);
      wr_reg(8'h0C, 8'hFF);
      rd_reg(8'h0C, d); check("R9 status write ignored", d, 8'h00);
      check("R9 irq after status write", {7'd0, irq}, 8'h00);

      // R3 R4 R8: full rollover 23:59:59 -> 00:00:00, binary 24h
      wr_reg(8'h0A, 8'h20);
      wr_reg(8'h00, 8'd59);
      wr_reg(8'h02, 8'd59);
      wr_reg(8'h04, 8'd23);
      rd_reg(8'h0C, d);
      set_idx(8'h0A);
      tick_en = 1'b1;
      d = 8'h00;
      while (!d[7]) rd_cur(d);
      rd_reg(8'h00, d); check("R4 time held during update window", d, 8'd59);
      repeat (20) @(negedge clk);
      rd_reg(8'h00, d); check("R3 seconds wrap", d, 8'd0);
      rd_reg(8'h02, d); check("R3 minutes wrap", d, 8'd0);
      rd_reg(8'h04, d); check("R3 hours wrap", d, 8'd0);
      rd_reg(8'h0C, d); check("R8 update flag", d, 8'h10);
      check("R10 no irq while disabled", {7'd0, irq}, 8'h00);

      // R7: rate zero never sets PF
      repeat (SECT + 40) @(negedge clk);
      rd_reg(8'h0C, d); check("R7 rate zero no PF", d & 8'h40, 8'h00);

      // R10 R8: update-ended interrupt
      wr_reg(8'h0B, 8'h16);
      rd_reg(8'h0C, d);
      wait_irq();
      rd_cur(d); check("R10 update irq status", d, 8'h90);
      n = 1;
      while (!irq) begin @(negedge clk); n++; end
      check("R3 one second in ticks", 8'(n >> 1), 8'(SECT >> 1));
      repeat (SECT + 44) begin
         @(negedge clk);
         if (!irq) check("R10 irq held", 8'h00, 8'h01);
      end
      check("R10 irq still high", {7'd0, irq}, 8'h01);
      rd_cur(d); check("R10 status after hold", d, 8'h90);
      check("R11 irq falls after read", {7'd0, irq}, 8'h00);

      // R7: periodic intervals for several rates
      wr_reg(8'h0B, 8'h46);
      for (int t = 0; t < 3; t++) begin
         logic [7:0] rsel;
         int expn;
         rsel = (t == 0) ? 8'h26 : (t == 1) ? 8'h27 : 8'h21;
         expn = (t == 0) ? 32 : (t == 1) ? 64 : 128;
         wr_reg(8'h0A, rsel);
         set_idx(8'h0C);
         rd_cur(d);
         wait_irq();
         rd_cur(d);
         n = 1;
         while (!irq) begin @(negedge clk); n++; end
         check("R7 periodic interval", 8'(n), 8'(expn));
         rd_cur(d);
         check("R9 status layout", d & 8'hEF, 8'hC0);
      end

      // R11: status read on the same edge as a periodic event
      wr_reg(8'h0A, 8'h26);
      set_idx(8'h0C);
      rd_cur(d);
      wait_irq();
      rd_cur(d);
      repeat (30) @(negedge clk);
      rd_cur(d); check("R11 read before event", d & 8'hC0, 8'h00);
      check("R11 irq kept after collision", {7'd0, irq}, 8'h01);
      rd_cur(d); check("R11 PF kept after collision", d & 8'hC0, 8'hC0);

      finish_run();
   end

endmodule